// File: doc/BRIEF.md
# Half-Bridge Short-Circuit Filter and Fault Latch

This block guards the four gate drivers of two half bridges. Each switch brings in an overcurrent comparator flag, an undervoltage flag and its own gate command. An overcurrent flag counts only while the switch is commanded on. It must stay present for an unbroken run of `FILT_CYCLES` clock cycles before it trips. Any gap restarts the run, so short repeated excursions never add up to a trip.

A trip latches a per-bridge fault that forces off both switches of that bridge. The fault stays set until the controller pulses the clear input. Undervoltage behaves differently: it forces off only the switch whose flag is raised, and it releases that switch as soon as the flag drops. An active-low error output is low whenever any switch is being forced off for either reason.

Switch index `2*b` is the high-side switch of bridge `b`, and index `2*b+1` is its low-side switch. The per-switch kill outputs go to the gate-drive stage, which turns a switch off whenever its kill bit is high.

Top module: `hb_scp_guard`

## Requirements
- R1: While reset is asserted, and after reset with all inputs low, no bridge fault is latched: `kill` is 0 and `err_n` is 1.
- R2: A bridge fault latches at the `FILT_CYCLES`-th consecutive rising clock edge at which one of its switches has both `gate_cmd` and `oc_det` high. After one edge fewer, no fault is latched.
- R3: A single edge at which the switch's `oc_det` or `gate_cmd` is low restarts that switch's run from zero. Exposure is never accumulated across gaps.
- R4: `oc_det` of a switch has no effect while that switch's `gate_cmd` is low, even when the other switch of the same bridge is commanded on.
- R5: A latched fault of bridge `b` sets `kill[2b]` and `kill[2b+1]`. It leaves the kill bits of the other bridge unchanged.
- R6: An edge with `err_clr` high clears every bridge fault and every filter run. This clear wins over a trip at the same edge.
- R7: A latched fault stays set while `err_clr` is low, even after the overcurrent flag and the gate commands return low.
- R8: `uv_flag[i]` high forces `kill[i]` high in the same cycle and affects no other switch. `kill[i]` falls again as soon as the flag drops, without any clear.
- R9: `err_n` is 0 exactly when some bridge fault is latched or some `uv_flag` bit is high. Otherwise it is 1.
- R10: After a clear, a switch whose overcurrent persists needs a full new run of `FILT_CYCLES` edges before it trips again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gate_cmd | input | NUM_BRIDGES*2 | Gate command per switch, 1 = on |
| oc_det | input | NUM_BRIDGES*2 | Overcurrent comparator flag per switch |
| uv_flag | input | NUM_BRIDGES*2 | Undervoltage flag per switch |
| err_clr | input | 1 | Fault clear request |
| kill | output | NUM_BRIDGES*2 | Per-switch forced-off command |
| err_n | output | 1 | Active-low error indication |

## Verification
On every cycle, the assertions check the following:
- A bridge fault only rises when a switch of that bridge has run for the full filter length with its gate on.
- A fault holds until a clear, and a clear empties every latch.
- Undervoltage forces exactly its own switch.
- The error output tracks the latched faults and undervoltage flags.

The bench scenarios show the behaviour that needs a designed input history:
- the exact trip edge, one cycle short versus on time;
- a one-cycle gap restarting the run;
- overcurrent ignored on an idle switch;
- clear winning against a trip that continues;
- a reset taken while a fault is latched.

// File: rtl/scp_pkg.sv
package scp_pkg;

  localparam int SW_PER_BRIDGE = 2;

  // Switch index to the half bridge that owns it
  function automatic int bridge_of(input int sw);
    return sw / SW_PER_BRIDGE;
  endfunction

endpackage

// File: rtl/scp_rst_sync.sv
module scp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_s_n = sync_q[STAGES-1];

endmodule

// File: rtl/scp_run_filter.sv
// Counts an unbroken run of qualified overcurrent cycles for one switch.
module scp_run_filter #(
  parameter int FILT_CYCLES = 900
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic oc,
  input  logic clr,
  output logic trip
);

  localparam int CW = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

  logic [CW-1:0] run_q;
  logic [CW-1:0] run_d;
  logic          run_en;
  logic          live;

  assign live = armed & oc & ~clr;

  always_comb begin
    run_en = 1'b1;
    run_d  = run_q;
    if (!live) begin
      run_d = '0;
    end else if (run_q != LAST) begin
      run_d = run_q + CW'(1);
    end else begin
      run_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (run_en) run_q <= run_d;
  end

  assign trip = live & (run_q == LAST);

endmodule

// File: rtl/scp_bridge_latch.sv
// Sticky short-circuit fault for one half bridge; clear has priority.
module scp_bridge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_any,
  input  logic clr,
  output logic fault
);

  logic fault_d;
  logic fault_en;

  always_comb begin
    fault_en = clr | trip_any;
    fault_d  = clr ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fault <= 1'b0;
    else if (fault_en) fault <= fault_d;
  end

endmodule

// File: rtl/hb_scp_guard.sv
module hb_scp_guard #(
  parameter int NUM_BRIDGES = 2,
  parameter int FILT_CYCLES = 900,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic [NUM_BRIDGES*scp_pkg::SW_PER_BRIDGE-1:0] gate_cmd,
  input  logic [NUM_BRIDGES*scp_pkg::SW_PER_BRIDGE-1:0] oc_det,
  input  logic [NUM_BRIDGES*scp_pkg::SW_PER_BRIDGE-1:0] uv_flag,
  input  logic                                       err_clr,
  output logic [NUM_BRIDGES*scp_pkg::SW_PER_BRIDGE-1:0] kill,
  output logic                                       err_n
);

  import scp_pkg::*;

  localparam int NSW = NUM_BRIDGES * SW_PER_BRIDGE;

  logic                   rst_s_n;
  logic [NSW-1:0]         sw_trip;
  logic [NUM_BRIDGES-1:0] sc_latch;

  scp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  for (genvar s = 0; s < NSW; s++) begin : g_sw
    localparam int B = bridge_of(s);
    logic armed;
    assign armed = gate_cmd[s] & ~sc_latch[B];

    scp_run_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
      .clk   (clk),
      .rst_n (rst_s_n),
      .armed (armed),
      .oc    (oc_det[s]),
      .clr   (err_clr),
      .trip  (sw_trip[s])
    );

    assign kill[s] = sc_latch[B] | uv_flag[s];
  end

  for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_br
    scp_bridge_latch u_latch (
      .clk      (clk),
      .rst_n    (rst_s_n),
      .trip_any (|sw_trip[b*SW_PER_BRIDGE +: SW_PER_BRIDGE]),
      .clr      (err_clr),
      .fault    (sc_latch[b])
    );
  end

  assign err_n = ~((|sc_latch) | (|uv_flag));

endmodule

// File: rtl/hb_scp_guard_chk.sv
module hb_scp_guard_chk #(
  parameter int NUM_BRIDGES = 2,
  parameter int FILT_CYCLES = 900
) (
  input logic                     clk,
  input logic                     rst_s_n,
  input logic [NUM_BRIDGES*2-1:0] gate_cmd,
  input logic [NUM_BRIDGES*2-1:0] oc_det,
  input logic [NUM_BRIDGES*2-1:0] uv_flag,
  input logic                     err_clr,
  input logic [NUM_BRIDGES*2-1:0] kill,
  input logic                     err_n,
  input logic [NUM_BRIDGES-1:0]   sc_latch
);

  localparam int NSW = NUM_BRIDGES * 2;
  localparam int RW  = $clog2(FILT_CYCLES + 1);
  localparam logic [RW-1:0] FULL = RW'(FILT_CYCLES);

  // Independent run counters, saturating at the filter length
  logic [RW-1:0] run [NSW];

  for (genvar s = 0; s < NSW; s++) begin : g_run
    always_ff @(posedge clk or negedge rst_s_n) begin
      if (!rst_s_n)                             run[s] <= '0;
      else if (err_clr || !(gate_cmd[s] && oc_det[s])) run[s] <= '0;
      else if (run[s] != FULL)                  run[s] <= run[s] + RW'(1);
    end

    // R8: undervoltage forces its own switch
    a_r8_uv_forces_kill: assert property (@(posedge clk) disable iff (!rst_s_n)
      uv_flag[s] |-> kill[s]);
    // R5 and R8: no kill without own bridge fault or own undervoltage
    a_r5_kill_scope: assert property (@(posedge clk) disable iff (!rst_s_n)
      (!uv_flag[s] && !sc_latch[s/2]) |-> !kill[s]);
  end

  for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_br
    // R2 and R3: a latch rises only after a full unbroken run
    a_r3_full_run: assert property (@(posedge clk) disable iff (!rst_s_n)
      $rose(sc_latch[b]) |-> (run[2*b] == FULL || run[2*b+1] == FULL));
    // R4: rise requires a commanded switch with overcurrent
    a_r4_gate_qualified: assert property (@(posedge clk) disable iff (!rst_s_n)
      $rose(sc_latch[b]) |-> $past(|(gate_cmd[2*b +: 2] & oc_det[2*b +: 2])));
    // R7: fault holds until cleared
    a_r7_latch_holds: assert property (@(posedge clk) disable iff (!rst_s_n)
      (sc_latch[b] && !err_clr) |=> sc_latch[b]);
  end

  // R6: clear empties every latch
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_s_n)
    err_clr |=> (sc_latch == '0));

  // R9: error output follows faults and undervoltage
  a_r9_err_tracks: assert property (@(posedge clk) disable iff (!rst_s_n)
    err_n == !((|sc_latch) || (|uv_flag)));

endmodule

bind hb_scp_guard hb_scp_guard_chk #(
  .NUM_BRIDGES (NUM_BRIDGES),
  .FILT_CYCLES (FILT_CYCLES)
) u_chk (
  .clk      (clk),
  .rst_s_n  (rst_s_n),
  .gate_cmd (gate_cmd),
  .oc_det   (oc_det),
  .uv_flag  (uv_flag),
  .err_clr  (err_clr),
  .kill     (kill),
  .err_n    (err_n),
  .sc_latch (sc_latch)
);

// File: tb/hb_scp_guard_bench.sv
module hb_scp_guard_bench;

  localparam int F = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] gate_cmd, oc_det, uv_flag;
  logic       err_clr;
  logic [3:0] kill;
  logic       err_n;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  hb_scp_guard #(.NUM_BRIDGES(2), .FILT_CYCLES(F)) u_hb_scp_guard (
    .clk(clk), .rst_n(rst_n), .gate_cmd(gate_cmd), .oc_det(oc_det),
    .uv_flag(uv_flag), .err_clr(err_clr), .kill(kill), .err_n(err_n)
  );

  typedef struct packed {
    logic [3:0] gate;
    logic [3:0] oc;
    logic [3:0] uv;
    logic       clr;
    logic [7:0] hold;
    logic [3:0] exp_kill;
    logic       exp_err_n;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{4'b0000, 4'b0000, 4'b0000, 1'b0, 8'd2,  4'b0000, 1'b1, 8'd1},  // R1 idle
    '{4'b0001, 4'b0001, 4'b0000, 1'b0, 8'd15, 4'b0000, 1'b1, 8'd2},  // R2 one short
    '{4'b0001, 4'b0001, 4'b0000, 1'b0, 8'd1,  4'b0011, 1'b0, 8'd2},  // R2 trip edge
    '{4'b0000, 4'b0000, 4'b0000, 1'b0, 8'd5,  4'b0011, 1'b0, 8'd7},  // R7 holds
    '{4'b0000, 4'b0000, 4'b0000, 1'b1, 8'd1,  4'b0000, 1'b1, 8'd6},  // R6 clear
    '{4'b0100, 4'b0100, 4'b0000, 1'b0, 8'd10, 4'b0000, 1'b1, 8'd3},  // R3 partial
    '{4'b0100, 4'b0000, 4'b0000, 1'b0, 8'd1,  4'b0000, 1'b1, 8'd3},  // R3 gap
    '{4'b0100, 4'b0100, 4'b0000, 1'b0, 8'd15, 4'b0000, 1'b1, 8'd3},  // R3 no accumulation
    '{4'b0100, 4'b0100, 4'b0000, 1'b0, 8'd1,  4'b1100, 1'b0, 8'd5},  // R5 bridge 1 only
    '{4'b0100, 4'b0100, 4'b0000, 1'b1, 8'd1,  4'b0000, 1'b1, 8'd6},  // R6 clear wins
    '{4'b0100, 4'b0100, 4'b0000, 1'b0, 8'd15, 4'b0000, 1'b1, 8'd10}, // R10 restart
    '{4'b0100, 4'b0100, 4'b0000, 1'b0, 8'd1,  4'b1100, 1'b0, 8'd10}, // R10 retrip
    '{4'b0000, 4'b1111, 4'b0000, 1'b1, 8'd1,  4'b0000, 1'b1, 8'd6},  // R6 clear
    '{4'b0000, 4'b1111, 4'b0000, 1'b0, 8'd40, 4'b0000, 1'b1, 8'd4},  // R4 gates off
    '{4'b0001, 4'b0010, 4'b0000, 1'b0, 8'd40, 4'b0000, 1'b1, 8'd4},  // R4 other switch
    '{4'b0000, 4'b0000, 4'b0010, 1'b0, 8'd1,  4'b0010, 1'b0, 8'd8},  // R8 uv own only
    '{4'b0000, 4'b0000, 4'b0000, 1'b0, 8'd1,  4'b0000, 1'b1, 8'd8},  // R8 self release
    '{4'b0010, 4'b0010, 4'b1000, 1'b0, 8'd16, 4'b1011, 1'b0, 8'd9},  // R9 both causes
    '{4'b0000, 4'b0000, 4'b1000, 1'b1, 8'd1,  4'b1000, 1'b0, 8'd9},  // R9 uv keeps err
    '{4'b0000, 4'b0000, 4'b0000, 1'b0, 8'd1,  4'b0000, 1'b1, 8'd9}   // R9 all clear
  };

  task automatic check(input string req, input logic [3:0] ek, input logic ee);
    checks++;
    if (kill !== ek || err_n !== ee) begin
      failures++;
      $display("FAIL %s: kill=%b err_n=%b expected kill=%b err_n=%b",
               req, kill, err_n, ek, ee);
    end
  endtask

  initial begin : watchdog
    #1_000_000;
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0; gate_cmd = '0; oc_det = '0; uv_flag = '0; err_clr = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 4'b0000, 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      gate_cmd = VEC[i].gate;
      oc_det   = VEC[i].oc;
      uv_flag  = VEC[i].uv;
      err_clr  = VEC[i].clr;
      repeat (int'(VEC[i].hold)) @(posedge clk);
      @(negedge clk);
      check($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].exp_kill, VEC[i].exp_err_n);
    end

    // R1: reset while a fault is latched
    err_clr = 1'b0; uv_flag = '0;
    gate_cmd = 4'b1000; oc_det = 4'b1000;
    repeat (F) @(posedge clk);
    @(negedge clk);
    check("R2 directed trip", 4'b1100, 1'b0);
    rst_n = 1'b0;
    #1;
    check("R1 reset drops latch", 4'b0000, 1'b1);
    gate_cmd = '0; oc_det = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after reset", 4'b0000, 1'b1);

    // R8: uv combinational, no latch
    uv_flag = 4'b0100;
    #1;
    check("R8 immediate", 4'b0100, 1'b0);
    uv_flag = 4'b0000;
    #1;
    check("R8 release", 4'b0000, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule